// File: doc/BRIEF.md
# In-Order Interlock Hazard Unit

This block decides, every cycle, whether the instruction sitting in the decode/register-read stage of a five-stage in-order pipeline may move into execute. The pipeline has no forwarding. A consumer therefore waits until its producer has reached writeback. The unit keeps a pending bit for each architectural register and a counter of flag-setting arithmetic instructions in flight. It combines these with the execute stage's multiply-busy signal and the branch redirect. From them it drives a single front-end hold (which freezes fetch and decode together), an issue strobe, a bubble request for the execute input latch and a decode squash.

A control state machine has three states. In RUN, instructions issue normally. In DRAIN, a halt has been decoded and issue is closed while older work completes. In DONE, nothing is outstanding. The transitions are:
- halt_seen: RUN to DRAIN, when an unsquashed halt is in decode.
- drain_empty: DRAIN to DONE, when no register or flag write is outstanding at the start of a cycle.
- Reset always returns the machine to RUN.

The register file itself lives elsewhere. It is write-before-read, so a writeback in the current cycle satisfies a same-cycle read.

Top module: `ilk_hazard_ctrl`

## Requirements
- R1: After reset the machine is in RUN with no pending register or flag write, `drained` is low, and a valid non-halt decode with any source fields issues at once (`dec_fire`=1, `hold_front`=0).
- R2: In RUN, a decode whose enabled source register was written by an issued instruction that has not yet written back is held: `hold_front`=1, `dec_fire`=0.
- R3: A writeback to register r in the same cycle (`wb_valid`=1, `wb_dst_en`=1, `wb_dst`=r) counts as complete, so a decode reading or writing r in that cycle is not held on r.
- R4: A decode whose enabled destination register already has an outstanding write is held until that write reaches writeback, so each register has at most one writer in flight.
- R5: A decode with `dec_reads_flag`=1 is held while any issued instruction with `dec_sets_flag`=1 has not written back. A flag writeback in the same cycle (`wb_sets_flag`=1) retires one such instruction.
- R6: While `ex_busy`=1, a valid decode is held, nothing issues, and `ex_bubble`=0 so the execute stage keeps its multiply.
- R7: `ex_bubble`=1 exactly when no instruction issues and `ex_busy`=0.
- R8: In RUN, `br_taken`=1 gives `dec_squash`=1, `dec_fire`=0 and `hold_front`=0. The squashed instruction leaves no pending write behind.
- R9: In RUN, a valid decode with `dec_is_halt`=1 and `br_taken`=0 is not issued, raises `hold_front`, and moves the machine to DRAIN. From then until reset, `hold_front`=1, `dec_fire`=0 and `dec_squash`=0 whatever the inputs.
- R10: `drained` rises in the cycle after the first DRAIN cycle that starts with no outstanding register or flag write, and stays high until reset.
- R11: `br_taken` takes priority over halt, hazard and multiply-busy holds in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_src_a | input | IDX_W | First source register index |
| dec_src_a_en | input | 1 | First source is read |
| dec_src_b | input | IDX_W | Second source register index |
| dec_src_b_en | input | 1 | Second source is read |
| dec_dst | input | IDX_W | Destination register index |
| dec_dst_en | input | 1 | Instruction writes a register |
| dec_sets_flag | input | 1 | Instruction updates the zero flag at writeback |
| dec_reads_flag | input | 1 | Instruction is a conditional branch on the zero flag |
| dec_is_halt | input | 1 | Instruction is a halt |
| wb_valid | input | 1 | Writeback stage holds an instruction |
| wb_dst | input | IDX_W | Register written at writeback |
| wb_dst_en | input | 1 | Writeback writes a register |
| wb_sets_flag | input | 1 | Writeback updates the zero flag |
| ex_busy | input | 1 | Multiply occupies execute for another cycle |
| br_taken | input | 1 | Branch in execute redirects fetch |
| hold_front | output | 1 | Freeze fetch and decode |
| dec_fire | output | 1 | Decode instruction moves into execute |
| ex_bubble | output | 1 | Load a NOP with valid low into execute |
| dec_squash | output | 1 | Discard the decode instruction |
| drained | output | 1 | Halted and all older writes completed |

## Verification
The bench builds the block with its default parameters: 16 registers (4-bit indices) and a 3-bit flag counter. Random register fields are drawn mostly from a small subset of those 16, so back-to-back read-after-write, write-after-write and same-cycle writeback collisions are frequent. Multiplies, flag setters, loads, stores and conditional branches are mixed at random. This keeps up to three flag setters in flight and lets a two-cycle multiply overlap decode holds and branch redirects. A directed halt late in the run is placed behind a random stream of older work, which exercises the drain-to-done timing against a pipeline model kept in the bench.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    // Issue control states
    typedef enum logic [1:0] {
        ILK_RUN   = 2'd0,   // normal issue
        ILK_DRAIN = 2'd1,   // halt seen, waiting for older writes
        ILK_DONE  = 2'd2    // nothing outstanding
    } ilk_state_e;

endpackage

// File: rtl/ilk_scoreboard.sv
module ilk_scoreboard #(
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [IDX_W-1:0]    set_idx,
    input  logic                clr_en,
    input  logic [IDX_W-1:0]    clr_idx,
    output logic [NUM_REGS-1:0] pending,
    output logic                any_pending
);

    logic [NUM_REGS-1:0] pend_q;

    // One pending bit per register; a new writer wins over a same-cycle retire
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_bit
        logic hit_set;
        logic hit_clr;
        assign hit_set = set_en && (set_idx == IDX_W'(i));
        assign hit_clr = clr_en && (clr_idx == IDX_W'(i));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[i] <= 1'b0;
            end else if (hit_set) begin
                pend_q[i] <= 1'b1;
            end else if (hit_clr) begin
                pend_q[i] <= 1'b0;
            end
        end
    end

    assign pending     = pend_q;
    assign any_pending = |pend_q;

    // R3
    sb_clear_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> pend_q[clr_idx]);

    // R4
    sb_single_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> (!pend_q[set_idx] || (clr_en && (clr_idx == set_idx))));

endmodule

// File: rtl/ilk_flag_tracker.sv
module ilk_flag_tracker #(
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,         // flag setter issued
    input  logic dec,         // flag setter at writeback
    output logic flag_wait,   // a setter still outstanding after this cycle's retire
    output logic flag_any     // any setter outstanding at start of cycle
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   cnt_q <= cnt_q + CNT_ONE;
                2'b01:   cnt_q <= cnt_q - CNT_ONE;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign flag_any  = (cnt_q != '0);
    assign flag_wait = dec ? (cnt_q > CNT_ONE) : flag_any;

    // R5
    flag_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt_q != '0));

    // R5
    flag_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec) |-> (cnt_q != CNT_MAX));

endmodule

// File: rtl/ilk_hazard_check.sv
module ilk_hazard_check #(
    parameter int NUM_REGS = 16,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0] pending,
    input  logic                clr_en,
    input  logic [IDX_W-1:0]    clr_idx,
    input  logic [IDX_W-1:0]    src_a,
    input  logic                src_a_en,
    input  logic [IDX_W-1:0]    src_b,
    input  logic                src_b_en,
    input  logic [IDX_W-1:0]    dst,
    input  logic                dst_en,
    input  logic                reads_flag,
    input  logic                flag_wait,
    output logic                hazard
);

    logic [NUM_REGS-1:0] live;
    logic [NUM_REGS-1:0] a_m;
    logic [NUM_REGS-1:0] b_m;
    logic [NUM_REGS-1:0] d_m;

    // Register still outstanding once this cycle's writeback is counted
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        assign live[i] = pending[i] && !(clr_en && (clr_idx == IDX_W'(i)));
        assign a_m[i]  = live[i] && src_a_en && (src_a == IDX_W'(i));
        assign b_m[i]  = live[i] && src_b_en && (src_b == IDX_W'(i));
        assign d_m[i]  = live[i] && dst_en   && (dst   == IDX_W'(i));
    end

    logic src_hit;
    logic dst_hit;
    logic flg_hit;

    assign src_hit = (|a_m) || (|b_m);
    assign dst_hit = |d_m;
    assign flg_hit = reads_flag && flag_wait;
    assign hazard  = src_hit || dst_hit || flg_hit;

endmodule

// File: rtl/ilk_hazard_ctrl.sv
module ilk_hazard_ctrl
    import ilk_pkg::*;
#(
    parameter int NUM_REGS   = 16,
    parameter int FLAG_CNT_W = 3,
    localparam int IDX_W     = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [IDX_W-1:0] dec_src_a,
    input  logic             dec_src_a_en,
    input  logic [IDX_W-1:0] dec_src_b,
    input  logic             dec_src_b_en,
    input  logic [IDX_W-1:0] dec_dst,
    input  logic             dec_dst_en,
    input  logic             dec_sets_flag,
    input  logic             dec_reads_flag,
    input  logic             dec_is_halt,
    input  logic             wb_valid,
    input  logic [IDX_W-1:0] wb_dst,
    input  logic             wb_dst_en,
    input  logic             wb_sets_flag,
    input  logic             ex_busy,
    input  logic             br_taken,
    output logic             hold_front,
    output logic             dec_fire,
    output logic             ex_bubble,
    output logic             dec_squash,
    output logic             drained
);

    ilk_state_e state_q;
    ilk_state_e state_d;

    logic [NUM_REGS-1:0] pending;
    logic                sb_any;
    logic                flag_wait;
    logic                flag_any;
    logic                hazard;
    logic                wb_clr;
    logic                wb_flag;
    logic                halt_take;

    assign wb_clr  = wb_valid && wb_dst_en;
    assign wb_flag = wb_valid && wb_sets_flag;

    ilk_scoreboard #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) sb_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_en      (dec_fire && dec_dst_en),
        .set_idx     (dec_dst),
        .clr_en      (wb_clr),
        .clr_idx     (wb_dst),
        .pending     (pending),
        .any_pending (sb_any)
    );

    ilk_flag_tracker #(
        .CNT_W (FLAG_CNT_W)
    ) flag_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (dec_fire && dec_sets_flag),
        .dec       (wb_flag),
        .flag_wait (flag_wait),
        .flag_any  (flag_any)
    );

    ilk_hazard_check #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) hz_i (
        .pending    (pending),
        .clr_en     (wb_clr),
        .clr_idx    (wb_dst),
        .src_a      (dec_src_a),
        .src_a_en   (dec_src_a_en),
        .src_b      (dec_src_b),
        .src_b_en   (dec_src_b_en),
        .dst        (dec_dst),
        .dst_en     (dec_dst_en),
        .reads_flag (dec_reads_flag),
        .flag_wait  (flag_wait),
        .hazard     (hazard)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ILK_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: halt_seen and drain_empty transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ILK_RUN:   if (halt_take) state_d = ILK_DRAIN;
            ILK_DRAIN: if (!sb_any && !flag_any) state_d = ILK_DONE;
            ILK_DONE:  state_d = ILK_DONE;
            default:   state_d = ILK_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        halt_take  = 1'b0;
        dec_fire   = 1'b0;
        hold_front = 1'b1;
        dec_squash = 1'b0;
        drained    = 1'b0;
        unique case (state_q)
            ILK_RUN: begin
                halt_take  = dec_valid && dec_is_halt && !br_taken;
                dec_squash = br_taken;
                dec_fire   = dec_valid && !br_taken && !dec_is_halt
                             && !ex_busy && !hazard;
                hold_front = dec_valid && !br_taken
                             && (dec_is_halt || ex_busy || hazard);
            end
            ILK_DRAIN: begin
                hold_front = 1'b1;
            end
            ILK_DONE: begin
                hold_front = 1'b1;
                drained    = 1'b1;
            end
            default: begin
                hold_front = 1'b1;
            end
        endcase
        ex_bubble = !dec_fire && !ex_busy;
    end

    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ILK_RUN) |=> (state_q != ILK_RUN));

    // R9
    drain_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ILK_RUN) |-> (hold_front && !dec_fire && !dec_squash));

    // R6
    busy_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_busy |-> (!dec_fire && !ex_bubble));

    // R2
    fire_src_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_fire && dec_src_a_en) |->
            (!pending[dec_src_a] || (wb_clr && (wb_dst == dec_src_a))));

    // R10
    done_only_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ILK_DONE) |-> (!sb_any && !flag_any));

    // R8
    squash_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_squash |-> (!dec_fire && !hold_front));

endmodule

// File: tb/ilk_hazard_ctrl_tb.sv
`timescale 1ns/1ps
module ilk_hazard_ctrl_tb_top;

    localparam int NCYC    = 3000;
    localparam int HALT_AT = 2600;

    typedef struct packed {
        logic       v;
        logic [3:0] sa;
        logic       sa_en;
        logic [3:0] sb;
        logic       sb_en;
        logic [3:0] d;
        logic       d_en;
        logic       sf;
        logic       rf;
        logic       mul;
        logic       br;
        logic       halt;
    } ins_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_valid = 0, dec_src_a_en = 0, dec_src_b_en = 0, dec_dst_en = 0;
    logic dec_sets_flag = 0, dec_reads_flag = 0, dec_is_halt = 0;
    logic [3:0] dec_src_a = 0, dec_src_b = 0, dec_dst = 0, wb_dst = 0;
    logic wb_valid = 0, wb_dst_en = 0, wb_sets_flag = 0, ex_busy = 0, br_taken = 0;
    logic hold_front, dec_fire, ex_bubble, dec_squash, drained;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ilk_hazard_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .dec_valid(dec_valid), .dec_src_a(dec_src_a), .dec_src_a_en(dec_src_a_en),
        .dec_src_b(dec_src_b), .dec_src_b_en(dec_src_b_en),
        .dec_dst(dec_dst), .dec_dst_en(dec_dst_en),
        .dec_sets_flag(dec_sets_flag), .dec_reads_flag(dec_reads_flag),
        .dec_is_halt(dec_is_halt),
        .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_dst_en(wb_dst_en),
        .wb_sets_flag(wb_sets_flag), .ex_busy(ex_busy), .br_taken(br_taken),
        .hold_front(hold_front), .dec_fire(dec_fire), .ex_bubble(ex_bubble),
        .dec_squash(dec_squash), .drained(drained)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d actual=%0b expected=%0b", tag, cyc, act, exp);
        end
    endtask

    function automatic logic [3:0] pick_reg();
        // mostly a small subset to provoke collisions
        if ($urandom_range(0, 3) != 0) return 4'($urandom_range(0, 3));
        return 4'($urandom_range(0, 15));
    endfunction

    function automatic ins_t gen_ins();
        ins_t x;
        int k;
        x = '0;
        x.v  = ($urandom_range(0, 99) < 85);
        k    = $urandom_range(0, 9);
        x.sa = pick_reg(); x.sb = pick_reg(); x.d = pick_reg();
        case (k)
            0, 1, 2: begin x.sa_en = 1; x.sb_en = 1; x.d_en = 1; x.sf = 1'($urandom_range(0, 1)); end
            3:       begin x.sa_en = 1; x.sb_en = 1; x.d_en = 1; x.sf = 1; x.mul = 1; end
            4:       begin x.sa_en = 1; x.d_en = 1; end             // load
            5:       begin x.sa_en = 1; x.sb_en = 1; end            // store
            6, 7:    begin x.rf = 1; x.br = 1; end                  // conditional branch
            8:       begin x.d_en = 1; end                          // move literal
            default: begin x.sa_en = 1; x.br = 1; end               // register jump
        endcase
        return x;
    endfunction

    function automatic logic pend_hit(input ins_t s, input logic en, input logic [3:0] r);
        return s.v && s.d_en && en && (s.d == r);
    endfunction

    ins_t dec_q, ex_q, mem_q, wb_q;
    logic ex_first;
    int   st;   // 0 run, 1 drain, 2 done

    initial begin
        void'($urandom(32'd20240611));
        dec_q = '0; ex_q = '0; mem_q = '0; wb_q = '0; ex_first = 0; st = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        dec_q = gen_ins();
        dec_q.v = 1; dec_q.halt = 0;

        for (int c = 0; c < NCYC; c++) begin
            logic busy, br, src_h, dst_h, flg_h, byp, haz, e_fire, e_hold, e_sq, outst, halt_t;
            string tag;
            @(negedge clk);
            cyc = c;
            if (c == HALT_AT && st == 0) begin
                dec_q = '0; dec_q.v = 1; dec_q.halt = 1;
            end
            busy = ex_q.v && ex_q.mul && ex_first;
            br   = ex_q.v && ex_q.br && ($urandom_range(0, 1) == 1);
            dec_valid = dec_q.v; dec_src_a = dec_q.sa; dec_src_a_en = dec_q.sa_en;
            dec_src_b = dec_q.sb; dec_src_b_en = dec_q.sb_en;
            dec_dst = dec_q.d; dec_dst_en = dec_q.d_en;
            dec_sets_flag = dec_q.sf; dec_reads_flag = dec_q.rf; dec_is_halt = dec_q.halt;
            wb_valid = wb_q.v; wb_dst = wb_q.d; wb_dst_en = wb_q.d_en; wb_sets_flag = wb_q.sf;
            ex_busy = busy; br_taken = br;
            #1;
            // outstanding producers are those in EX or MEM; WB completes this cycle (R3)
            src_h = pend_hit(ex_q, dec_q.sa_en, dec_q.sa) || pend_hit(mem_q, dec_q.sa_en, dec_q.sa)
                 || pend_hit(ex_q, dec_q.sb_en, dec_q.sb) || pend_hit(mem_q, dec_q.sb_en, dec_q.sb);
            dst_h = pend_hit(ex_q, dec_q.d_en, dec_q.d) || pend_hit(mem_q, dec_q.d_en, dec_q.d);
            flg_h = dec_q.rf && ((ex_q.v && ex_q.sf) || (mem_q.v && mem_q.sf));
            byp   = pend_hit(wb_q, dec_q.sa_en, dec_q.sa) || pend_hit(wb_q, dec_q.sb_en, dec_q.sb)
                 || pend_hit(wb_q, dec_q.d_en, dec_q.d) || (dec_q.rf && wb_q.v && wb_q.sf);
            haz = src_h || dst_h || flg_h;
            if (st == 0) begin
                e_sq   = br;
                e_fire = dec_q.v && !br && !dec_q.halt && !busy && !haz;
                e_hold = dec_q.v && !br && (dec_q.halt || busy || haz);
            end else begin
                e_sq = 0; e_fire = 0; e_hold = 1;
            end
            if (c == 0)                         tag = "R1 reset state";
            else if (st != 0)                   tag = "R9 halted issue";
            else if (br && (dec_q.halt || haz || busy)) tag = "R11 redirect priority";
            else if (br)                        tag = "R8 redirect";
            else if (dec_q.v && dec_q.halt)     tag = "R9 halt decode";
            else if (busy)                      tag = "R6 multiply busy";
            else if (flg_h)                     tag = "R5 flag interlock";
            else if (dst_h)                     tag = "R4 destination interlock";
            else if (src_h)                     tag = "R2 source interlock";
            else if (byp)                       tag = "R3 writeback same cycle";
            else                                tag = "R1 free issue";
            chk({tag, " dec_fire"}, dec_fire, e_fire);
            chk({tag, " hold_front"}, hold_front, e_hold);
            chk("R8 dec_squash", dec_squash, e_sq);
            chk("R7 ex_bubble", ex_bubble, !e_fire && !busy);
            chk("R10 drained", drained, st == 2);

            // advance the bench pipeline model
            outst = (ex_q.v && (ex_q.d_en || ex_q.sf)) || (mem_q.v && (mem_q.d_en || mem_q.sf))
                 || (wb_q.v && (wb_q.d_en || wb_q.sf));
            halt_t = (st == 0) && dec_q.v && dec_q.halt && !br;
            if (halt_t) st = 1;
            else if (st == 1 && !outst) st = 2;
            wb_q = mem_q;
            if (busy) begin
                mem_q = '0; ex_first = 0;
            end else begin
                mem_q = ex_q;
                ex_q  = e_fire ? dec_q : '0;
                ex_first = e_fire && dec_q.mul;
            end
            if (e_fire || br || !dec_q.v || halt_t || st != 0) dec_q = gen_ins();
        end
        finished = 1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired at cycle %0d actual=hung expected=done", cyc);
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule